// File: doc/BRIEF.md
# Trace Ring Pointer and Status Controller

This block runs a circular trace store built on one single-ported RAM. Each traced event arrives as a write strobe with a payload. The block appends to that payload a timestamp, which is the number of ticks since the previous traced event, and a flag that marks a gap in the trace. The entry is then stored at the write pointer. Software reads the store back through a request/response port. Each 69-bit entry is returned as two 64-bit words. The upper word carries a two-bit status that tells whether the entry is valid and whether events were lost before it.

The controller keeps a write pointer and a read pointer, each with one extra wrap bit. From them it derives the fill level, full and empty. It offers two modes. In the continuous mode, writes stall while the ring is full and resume once a read frees a slot. In the one-shot mode, capture stops for good after the ring has been filled once. A selectable fill threshold raises a one-cycle interrupt each time the distance between the pointers climbs to that level.

Top module: `trace_ring_ctl`

## Requirements
- R1: A rising edge of `trace_en` returns both pointers to entry 0. Entries stored before it are no longer readable, and the next accepted write is read back first.
- R2: With `wrap_mode`=1 and the ring full, write strobes are dropped. Once a read frees a slot, the next accepted write is stored with its gap flag set, so its status reads 3.
- R3: With `wrap_mode`=0, capture stops after DEPTH accepted writes since enable. Later strobes are not stored, even after reads free space.
- R4: A read of an empty ring returns 0 in both words and does not move the read pointer.
- R5: The status is bits [4:3] of the second word. A stored entry with no preceding loss reads 2 (binary 10). Bit 4 is the valid bit.
- R6: The first word of a read returns entry bits [63:0], which are the payload bits [55:0] above the 8-bit timestamp in bits [7:0]. The second word returns entry bits [68:64] in bits [4:0]: valid, gap flag, and payload bits [58:56]. Its bits [63:5] are 0. The read pointer advances only when the second word is served.
- R7: A read request is granted in the first cycle in which no trace write is using the RAM. `rd_valid` rises one cycle after the grant. Responses come back in request order. A read requested in the same cycle as a write to an empty ring returns that entry.
- R8: The timestamp field counts the tick edges strictly between the previous accepted write (or the enable edge) and this write, saturating at 255. Back-to-back writes read 0.
- R9: A tick occurs on every 2^`tick_gran` clock edges, counted from the enable edge. With `tick_gran`=0 there is one tick per cycle.
- R10: `thresh_sel` codes are 0 = off, 1 = DEPTH/2, 2 = 3*DEPTH/4 and 3 = DEPTH. `irq` pulses for exactly one cycle, the cycle after the write edge at which the fill level first reaches the chosen level. It does not pulse again until the fill has dropped below that level and reached it again. It is low after reset and never pulses when the code is 0.
- R11: While `trace_en` is low, write strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trace_en | input | 1 | Capture enable; its rising edge restarts the ring |
| wrap_mode | input | 1 | 1 = continuous capture with stall when full, 0 = one-shot capture |
| thresh_sel | input | 2 | Interrupt fill level: 0 off, 1 half, 2 three quarters, 3 full |
| tick_gran | input | GRAN_W | Timestamp tick period is 2^tick_gran clock cycles |
| wr_valid | input | 1 | Trace event strobe |
| wr_payload | input | ENTRY_W-2-TS_W | Event payload stored above the timestamp |
| rd_req | input | 1 | One-cycle request for the next read word |
| rd_valid | output | 1 | Read word is valid this cycle |
| rd_data | output | DATA_W | Read word: lower entry bits, or status plus upper entry bits |
| irq | output | 1 | One-cycle fill threshold interrupt |

## Verification
The assertions assume that a requester issues a new `rd_req` only after the response to the previous one has come back. They also assume that `trace_en` does not rise while a read is in flight, since the restart cancels outstanding reads. The bench follows both rules: it raises `rd_req` for a single cycle, waits for `rd_valid` before the next request, and toggles the enable only while no read is pending. `tick_gran` is changed only in the same cycle as a write edge, so the reference tick count stays valid across the change.

// File: rtl/trace_ring_pkg.sv
`timescale 1ns/1ps
package trace_ring_pkg;

    // Fill threshold choice for the interrupt
    typedef enum logic [1:0] {
        LVL_OFF  = 2'd0,
        LVL_HALF = 2'd1,
        LVL_3Q   = 2'd2,
        LVL_FULL = 2'd3
    } lvl_sel_e;

endpackage

// File: rtl/trace_ring_ram.sv
`timescale 1ns/1ps
// Single-port storage; a write takes the port, otherwise a read registers data.
module trace_ring_ram #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 68,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem_q[addr] <= wdata;
            end else begin
                rdata_q <= mem_q[addr];
            end
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/trace_ring_stamp.sv
`timescale 1ns/1ps
// Tick prescaler and saturating delta counter between traced events.
module trace_ring_stamp #(
    parameter int TS_W   = 8,
    parameter int GRAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              event_hit,
    input  logic [GRAN_W-1:0] gran,
    output logic [TS_W-1:0]   delta
);

    localparam int PRE_W = (1 << GRAN_W) - 1;

    logic [PRE_W-1:0] presc_d, presc_q;
    logic [TS_W-1:0]  cnt_d, cnt_q;
    logic [PRE_W-1:0] mask;
    logic             tick;

    assign mask = ~({PRE_W{1'b1}} << gran);
    assign tick = (presc_q & mask) == mask;

    always_comb begin
        presc_d = presc_q + 1'b1;
        cnt_d   = cnt_q;
        if (restart) begin
            presc_d = '0;
            cnt_d   = '0;
        end else if (event_hit) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != {TS_W{1'b1}})) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            cnt_q   <= '0;
        end else begin
            presc_q <= presc_d;
            cnt_q   <= cnt_d;
        end
    end

    assign delta = cnt_q;

endmodule

// File: rtl/trace_ring_level.sv
`timescale 1ns/1ps
// Upward-crossing detector of the selected fill threshold.
module trace_ring_level
    import trace_ring_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int PW    = $clog2(DEPTH) + 1
) (
    input  logic [PW-1:0] fill_cur,
    input  logic [PW-1:0] fill_nxt,
    input  logic [1:0]    sel,
    output logic          hit
);

    localparam logic [PW-1:0] LV_HALF = PW'(DEPTH / 2);
    localparam logic [PW-1:0] LV_3Q   = PW'((DEPTH * 3) / 4);
    localparam logic [PW-1:0] LV_FULL = PW'(DEPTH);

    logic [PW-1:0] level;
    logic          armed;

    always_comb begin
        armed = 1'b1;
        level = LV_FULL;
        unique case (lvl_sel_e'(sel))
            LVL_OFF:  armed = 1'b0;
            LVL_HALF: level = LV_HALF;
            LVL_3Q:   level = LV_3Q;
            LVL_FULL: level = LV_FULL;
            default:  armed = 1'b0;
        endcase
        hit = armed && (fill_nxt >= level) && (fill_cur < level);
    end

endmodule

// File: rtl/trace_ring_ctl.sv
`timescale 1ns/1ps
// Trace ring: pointers, overflow stall, gap marking, split reads, threshold irq.
module trace_ring_ctl #(
    parameter int DEPTH   = 1024,
    parameter int ENTRY_W = 69,
    parameter int DATA_W  = 64,
    parameter int TS_W    = 8,
    parameter int GRAN_W  = 3,
    localparam int PAY_W  = ENTRY_W - 2 - TS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trace_en,
    input  logic              wrap_mode,
    input  logic [1:0]        thresh_sel,
    input  logic [GRAN_W-1:0] tick_gran,
    input  logic              wr_valid,
    input  logic [PAY_W-1:0]  wr_payload,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    localparam int AW      = $clog2(DEPTH);
    localparam int PW      = AW + 1;
    localparam int STORE_W = ENTRY_W - 1;       // valid bit is made at read time
    localparam int HOLD_W  = STORE_W - DATA_W;  // gap flag + upper payload bits
    localparam int HI_W    = ENTRY_W - DATA_W;  // bits returned in second word

    typedef struct packed {
        logic [PW-1:0]     wr_ptr;
        logic [PW-1:0]     rd_ptr;
        logic              en_prev;
        logic              filled;
        logic              gap_pend;
        logic              pend;
        logic              phase;
        logic              ret;
        logic              ret_hi;
        logic              ent_valid;
        logic [HOLD_W-1:0] hold;
        logic              irq;
    } state_t;

    state_t d, q;

    logic               start, accept, drop, full, empty, wr_block;
    logic               req_act, grant, grant0, grant1;
    logic [PW-1:0]      fill_cur, fill_nxt, wr_ptr_nxt, rd_ptr_nxt, rd_ptr_cur;
    logic               lvl_hit, hi_word;
    logic               ram_en, ram_we;
    logic [AW-1:0]      ram_addr;
    logic [STORE_W-1:0] ram_wdata, ram_rdata;
    logic [TS_W-1:0]    delta;

    // ---------------- control decode ----------------
    assign start      = trace_en & ~q.en_prev;
    assign fill_cur   = q.wr_ptr - q.rd_ptr;
    assign full       = (fill_cur == PW'(DEPTH));
    assign empty      = (fill_cur == '0);
    assign wr_block   = wrap_mode ? full : q.filled;
    assign accept     = wr_valid & trace_en & ~start & ~wr_block;
    assign drop       = wr_valid & trace_en & ~start & wrap_mode & full;
    assign req_act    = (rd_req | q.pend) & ~start;
    assign grant      = req_act & (q.phase | ~accept);
    assign grant0     = grant & ~q.phase;
    assign grant1     = grant & q.phase;
    assign rd_ptr_cur = q.rd_ptr;
    assign hi_word    = q.ret_hi;

    assign wr_ptr_nxt = start ? '0 : q.wr_ptr + PW'(accept);
    assign rd_ptr_nxt = start ? '0 : q.rd_ptr + PW'(grant1 & q.ent_valid);
    assign fill_nxt   = wr_ptr_nxt - rd_ptr_nxt;

    // ---------------- RAM port arbitration ----------------
    assign ram_en    = accept | grant0;
    assign ram_we    = accept;
    assign ram_addr  = accept ? q.wr_ptr[AW-1:0] : q.rd_ptr[AW-1:0];
    assign ram_wdata = {q.gap_pend, wr_payload, delta};

    trace_ring_ram #(
        .DEPTH (DEPTH),
        .WIDTH (STORE_W),
        .AW    (AW)
    ) ram_i (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    trace_ring_stamp #(
        .TS_W   (TS_W),
        .GRAN_W (GRAN_W)
    ) stamp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (start),
        .event_hit (accept),
        .gran      (tick_gran),
        .delta     (delta)
    );

    trace_ring_level #(
        .DEPTH (DEPTH),
        .PW    (PW)
    ) level_i (
        .fill_cur (fill_cur),
        .fill_nxt (fill_nxt),
        .sel      (thresh_sel),
        .hit      (lvl_hit)
    );

    // ---------------- next state ----------------
    always_comb begin
        d         = q;
        d.en_prev = trace_en;
        d.wr_ptr  = wr_ptr_nxt;
        d.rd_ptr  = rd_ptr_nxt;
        d.ret     = grant;
        d.ret_hi  = grant1;
        d.irq     = lvl_hit;

        if (q.ret && !q.ret_hi) begin
            d.hold = ram_rdata[STORE_W-1:DATA_W];
        end

        if (start) begin
            d.filled    = 1'b0;
            d.gap_pend  = 1'b0;
            d.pend      = 1'b0;
            d.phase     = 1'b0;
            d.ent_valid = 1'b0;
        end else begin
            if (accept) begin
                d.gap_pend = 1'b0;
                if (q.wr_ptr[AW-1:0] == {AW{1'b1}}) begin
                    d.filled = 1'b1;
                end
            end
            if (drop) begin
                d.gap_pend = 1'b1;
            end
            d.pend = req_act & ~grant;
            if (grant0) begin
                d.phase     = 1'b1;
                d.ent_valid = ~empty;
            end
            if (grant1) begin
                d.phase = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // ---------------- read word formatting ----------------
    always_comb begin
        rd_data = '0;
        if (hi_word) begin
            rd_data[HI_W-1] = q.ent_valid;
            rd_data[HI_W-2] = q.ent_valid & q.hold[HOLD_W-1];
            rd_data[HOLD_W-2:0] = q.ent_valid ? q.hold[HOLD_W-2:0] : '0;
        end else if (q.ent_valid) begin
            rd_data = ram_rdata[DATA_W-1:0];
        end
    end

    assign rd_valid = q.ret;
    assign irq      = q.irq;

endmodule

// File: rtl/trace_ring_ctl_chk.sv
`timescale 1ns/1ps
module trace_ring_ctl_chk #(
    parameter int DEPTH = 1024,
    parameter int PW    = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic          rd_valid,
    input logic          stat_valid,
    input logic          hi_word,
    input logic          grant,
    input logic          start,
    input logic [PW-1:0] fill,
    input logic [PW-1:0] rd_ptr
);

    // R10: the threshold interrupt is a single-cycle pulse
    assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R2: the distance between the pointers never exceeds the ring size
    assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= PW'(DEPTH));

    // R7: every response follows a grant by exactly one cycle
    assert_resp_after_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(grant));

    // R4: an empty-ring read leaves the read pointer where it was
    assert_underflow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && hi_word && !stat_valid) |-> $stable(rd_ptr));

    // R6: the read pointer moves only with a second-word response or a restart
    assert_ptr_moves_on_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr != $past(rd_ptr)) |-> ($past(start) || (rd_valid && hi_word)));

endmodule

bind trace_ring_ctl trace_ring_ctl_chk #(
    .DEPTH (DEPTH),
    .PW    (PW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .rd_valid   (rd_valid),
    .stat_valid (rd_data[HI_W-1]),
    .hi_word    (hi_word),
    .grant      (grant),
    .start      (start),
    .fill       (fill_cur),
    .rd_ptr     (rd_ptr_cur)
);

// File: tb/trace_ring_ctl_tb_top.sv
`timescale 1ns/1ps
module trace_ring_ctl_tb_top;

    localparam int DEPTH = 16;
    localparam int PAY_W = 59;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trace_en = 1'b0;
    logic              wrap_mode = 1'b1;
    logic [1:0]        thresh_sel = 2'd0;
    logic [2:0]        tick_gran = 3'd0;
    logic              wr_valid = 1'b0;
    logic [PAY_W-1:0]  wr_payload = '0;
    logic              rd_req = 1'b0;
    logic              rd_valid;
    logic [63:0]       rd_data;
    logic              irq;

    always #2 clk = ~clk;

    trace_ring_ctl #(.DEPTH(DEPTH)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .trace_en   (trace_en),
        .wrap_mode  (wrap_mode),
        .thresh_sel (thresh_sel),
        .tick_gran  (tick_gran),
        .wr_valid   (wr_valid),
        .wr_payload (wr_payload),
        .rd_req     (rd_req),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .irq        (irq)
    );

    int n_chk = 0, n_bad = 0, resp_cnt = 0, irq_seen = 0, exp_irq = 0;
    int edge_cnt = 0, cyc = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    // reference model state
    logic [67:0] m_q[$];
    int  m_total = 0, m_last = 0, m_start = 0;
    bit  m_gap = 0, m_en = 0, m_wrap = 1;
    int  m_sel = 0;

    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: scoreboard pop and interrupt count
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected response", rd_data, 64'd0);
                end else begin
                    logic [63:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(rd_data === e, t, rd_data, e);
                end
                resp_cnt++;
            end
            if (irq) irq_seen++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [PAY_W-1:0] pay(input int k);
        logic [63:0] v;
        v = (64'h9E37_79B9_7F4A_7C15 * 64'(k + 1)) ^ (64'(k) << 56);
        return v[PAY_W-1:0];
    endfunction

    function automatic int ticks(input int a, input int b);
        int c = 0;
        int mask = (1 << tick_gran) - 1;
        for (int j = a + 1; j < b; j++)
            if (((j - m_start - 1) & mask) == mask) c++;
        return (c > 255) ? 255 : c;
    endfunction

    function automatic int level(input int s);
        case (s)
            1: return DEPTH / 2;
            2: return (DEPTH * 3) / 4;
            3: return DEPTH;
            default: return 1000000;
        endcase
    endfunction

    task automatic model_write(input logic [PAY_W-1:0] p, input int w);
        if (m_en && (m_wrap ? (m_q.size() < DEPTH) : (m_total < DEPTH))) begin
            int ts = ticks(m_last, w);
            m_q.push_back({m_gap, p, 8'(ts)});
            if (m_q.size() == level(m_sel)) exp_irq++;
            m_gap = 0;
            m_total++;
            m_last = w;
        end else if (m_en && m_wrap) begin
            m_gap = 1;
        end
    endtask

    task automatic wr_burst(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_valid   = 1'b1;
            wr_payload = pay(seed + i);
            model_write(pay(seed + i), edge_cnt + 1);
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic expect_entry(input string tag);
        if (m_q.size() == 0) begin
            exp_q.push_back(64'd0); tag_q.push_back({tag, " underflow word0"});
            exp_q.push_back(64'd0); tag_q.push_back({tag, " underflow word1"});
        end else begin
            logic [67:0] e;
            e = m_q.pop_front();
            exp_q.push_back(e[63:0]); tag_q.push_back({tag, " word0"});
            exp_q.push_back({59'd0, 1'b1, e[67], e[66:64]}); tag_q.push_back({tag, " word1"});
        end
    endtask

    task automatic wait_resp(input int b);
        while (resp_cnt == b) @(negedge clk);
    endtask

    task automatic req_word();
        int b;
        @(negedge clk);
        b = resp_cnt;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        wait_resp(b);
    endtask

    task automatic read_entry(input string tag);
        expect_entry(tag);
        req_word();
        req_word();
    endtask

    task automatic restart(input bit wrap);
        @(negedge clk);
        trace_en  = 1'b0;
        wrap_mode = wrap;
        @(negedge clk);
        trace_en = 1'b1;
        m_start = edge_cnt + 1;
        m_last  = m_start;
        m_q.delete();
        m_total = 0;
        m_gap   = 0;
        m_en    = 1;
        m_wrap  = wrap;
    endtask

    task automatic set_sel(input int s);
        @(negedge clk);
        thresh_sel = 2'(s);
        m_sel = s;
    endtask

    task automatic chk_irq(input string tag);
        repeat (2) @(negedge clk);
        check(irq_seen == exp_irq, tag, 64'(irq_seen), 64'(exp_irq));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_valid == 1'b0, "R7 reset rd_valid", 64'(rd_valid), 64'd0);
        check(irq == 1'b0, "R10 reset irq", 64'(irq), 64'd0);

        // R11: disabled capture ignores strobes; R4: empty read
        wr_burst(2, 100);
        read_entry("R11 disabled write ignored");
        read_entry("R4 empty read");

        // R5 R6 R8: basic capture with per-cycle ticks
        restart(1'b1);
        wr_burst(3, 0);
        repeat (5) @(negedge clk);
        wr_burst(1, 3);
        read_entry("R5 status valid");
        read_entry("R6 split read");
        read_entry("R8 back-to-back stamp");
        read_entry("R8 gap stamp");

        // R8 saturation
        repeat (300) @(negedge clk);
        wr_burst(1, 4);
        tick_gran = 3'd2;
        read_entry("R8 saturated stamp");

        // R9 coarser ticks
        repeat (9) @(negedge clk);
        wr_burst(1, 5);
        repeat (6) @(negedge clk);
        wr_burst(1, 6);
        read_entry("R9 granular stamp a");
        read_entry("R9 granular stamp b");

        // R10 thresholds
        set_sel(1);
        wr_burst(8, 10);
        chk_irq("R10 half level");
        read_entry("R10 drain one");
        wr_burst(1, 18);
        chk_irq("R10 half level again");
        set_sel(2);
        wr_burst(4, 19);
        chk_irq("R10 three quarter level");
        set_sel(3);
        wr_burst(4, 23);
        chk_irq("R10 full level");

        // R2: overflow stall and gap flag
        wr_burst(2, 27);
        read_entry("R2 read while full");
        wr_burst(1, 29);
        chk_irq("R10 full level reached again");
        for (int i = 0; i < DEPTH; i++) read_entry("R2 drain with gap entry");
        read_entry("R4 empty after drain");

        // R1: restart discards old entries
        wr_burst(3, 40);
        restart(1'b1);
        read_entry("R1 restart empties ring");
        wr_burst(1, 43);
        read_entry("R1 first entry after restart");

        // R3: one-shot capture, threshold off
        set_sel(0);
        restart(1'b0);
        wr_burst(DEPTH, 50);
        read_entry("R3 one-shot first");
        wr_burst(1, 70);
        for (int i = 0; i < DEPTH - 1; i++) read_entry("R3 one-shot drain");
        read_entry("R3 no capture after fill");
        chk_irq("R10 off never fires");

        // R7: read and write in the same cycle on an empty ring
        restart(1'b1);
        begin
            int b;
            @(negedge clk);
            wr_valid   = 1'b1;
            wr_payload = pay(80);
            rd_req     = 1'b1;
            model_write(pay(80), edge_cnt + 1);
            expect_entry("R7 write wins port");
            b = resp_cnt;
            @(negedge clk);
            wr_valid = 1'b0;
            rd_req   = 1'b0;
            wait_resp(b);
            req_word();
        end

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R7 all responses returned", 64'(exp_q.size()), 64'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule